// File: doc/BRIEF.md
# LCD Controller Register Interface

This block is the register front end of a colour LCD controller. It sits on an APB-style bus and decodes a 4 KB window. The window holds four timing words, an upper and a lower frame base address, a control word, an interrupt mask, and raw and masked interrupt status with a write-one-to-clear port. It also holds a row of read-only identification bytes. From two of the timing words it derives the active panel geometry: pixels per line and lines per panel. The timing generator, the DMA engine and the pixel pipeline read this geometry.

Interrupt sources outside the block arrive as one-cycle event pulses. The block latches them into raw status and raises a level interrupt whenever an enabled bit is pending. Accesses that fall into the palette sub-range are passed to a separate palette store. A variant input selects how the interface appears to software. On every variant except the basic one, the control word and the interrupt mask trade addresses. The extended variant also reports different identification bytes. Every write to the window produces a one-cycle redraw request, so the display path can refresh its cached state.

Top module: `lcd_regif`

## Requirements
- R1: Word offsets 0–3 hold timing words 0–3 and offsets 4 and 5 hold the upper and lower frame bases (32 bits each, read/write). Offsets 11 and 12 read back the upper and lower base as current-address registers.
- R2: With variant 0 (basic), offset 6 is the interrupt mask (low 5 bits) and offset 7 is control (low 16 bits). With variants 1, 2 and 3 these two addresses are swapped.
- R3: Active columns equal (timing0 bits [7:2] + 1) × 16. The other bits of timing0 do not affect them.
- R4: Active rows equal timing1 bits [9:0] + 1. The other bits of timing1 do not affect them.
- R5: A 1 on an event input bit sets the matching raw status bit on the next clock edge. Offset 8 reads raw status.
- R6: Offset 9 reads raw status AND mask. The interrupt output is high exactly when that value is nonzero.
- R7: A write to offset 10 clears every raw bit written as 1. An event on the same bit in the same cycle wins, and the bit stays set.
- R8: Offsets 0xFE0–0xFFC return one byte per word, indexed by address bits [4:2]. Variants 0 and 1 return 10 11 04 00 0D F0 05 B1. Variants 2 and 3 return 11 11 24 00 0D F0 05 B1.
- R9: Reads of undefined offsets, including offset 10, return zero. Writes to them change no register.
- R10: Byte addresses 0x200–0x3FF assert the palette select. A write there also asserts the palette write strobe. The palette word index is address bits [8:2], and a read returns the palette read data.
- R11: Every write access (psel, penable and pwrite high) makes the redraw output high for exactly the next cycle.
- R12: After reset, all registers and status read zero, the geometry is 16 columns by 1 row, and the interrupt and redraw outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| variant | input | 2 | Interface variant: 0 basic, 1 swapped, 2/3 extended |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase |
| pwrite | input | 1 | 1 write, 0 read |
| paddr | input | 12 | Byte address in the window |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, combinational, zero when not reading |
| irq_evt | input | 5 | Interrupt event pulses |
| irq | output | 1 | Level interrupt |
| redraw | output | 1 | One-cycle redraw request |
| active_cols | output | 11 | Pixels per line |
| active_rows | output | 11 | Lines per panel |
| pal_sel | output | 1 | Palette range selected |
| pal_write | output | 1 | Palette write strobe |
| pal_addr | output | 7 | Palette word index |
| pal_wdata | output | 32 | Palette write data |
| pal_rdata | input | 32 | Palette read data |

## Verification
The bench reads offsets 6 and 7 under each variant. A design that ignored the variant would return the mask where control was expected. It puts all-ones and all-zeros into the timing words, so a wrong offset or a missing field mask shows up as a geometry off by one or off by 16. It also sends an event pulse in the same cycle as a clear of that bit; a design where the clear wins would lose the interrupt. Writes to undefined offsets and to the palette range are followed by read-back of the real registers, which exposes any decode that aliases onto a register.

// File: rtl/lcd_regif_pkg.sv
package lcd_regif_pkg;
    localparam int ADDR_W   = 12;
    localparam int DATA_W   = 32;
    localparam int NIRQ     = 5;
    localparam int CTRL_W   = 16;
    localparam int GEOM_W   = 11;
    localparam int PAL_AW   = 7;
    localparam int NTIM     = 4;
    localparam int IDX_W    = $clog2(NTIM);

    typedef enum logic [1:0] {
        VAR_BASIC = 2'd0,
        VAR_BOARD = 2'd1,
        VAR_EXT   = 2'd2,
        VAR_EXT2  = 2'd3
    } variant_e;

    typedef enum logic [3:0] {
        SEL_NONE, SEL_TIM, SEL_UBASE, SEL_LBASE, SEL_MASK, SEL_CTRL,
        SEL_RAW, SEL_MSTAT, SEL_CLR, SEL_UCUR, SEL_LCUR, SEL_ID, SEL_PAL
    } sel_e;

    typedef struct packed {
        sel_e             sel;
        logic [IDX_W-1:0] tim_idx;
        logic [2:0]       id_idx;
    } decode_t;

    function automatic logic [7:0] id_byte(input logic ext, input logic [2:0] idx);
        case (idx)
            3'd0: id_byte = ext ? 8'h11 : 8'h10;
            3'd1: id_byte = 8'h11;
            3'd2: id_byte = ext ? 8'h24 : 8'h04;
            3'd3: id_byte = 8'h00;
            3'd4: id_byte = 8'h0D;
            3'd5: id_byte = 8'hF0;
            3'd6: id_byte = 8'h05;
            default: id_byte = 8'hB1;
        endcase
    endfunction
endpackage

// File: rtl/lcd_regif_decode.sv
module lcd_regif_decode
    import lcd_regif_pkg::*;
(
    input  logic [ADDR_W-1:0] paddr,
    input  variant_e          variant,
    output decode_t           dec
);
    localparam logic [ADDR_W-1:0] ID_BASE = ADDR_W'(12'hFE0);
    logic swap;
    logic [ADDR_W-3:0] word;

    assign swap = (variant != VAR_BASIC);
    assign word = paddr[ADDR_W-1:2];

    always_comb begin
        dec.sel     = SEL_NONE;
        dec.tim_idx = paddr[2+IDX_W-1:2];
        dec.id_idx  = paddr[4:2];
        if (paddr >= ID_BASE) begin
            dec.sel = SEL_ID;
        end else if (paddr[ADDR_W-1:9] == 3'b001) begin
            dec.sel = SEL_PAL;
        end else begin
            case (word)
                10'd0, 10'd1, 10'd2, 10'd3: dec.sel = SEL_TIM;
                10'd4:  dec.sel = SEL_UBASE;
                10'd5:  dec.sel = SEL_LBASE;
                10'd6:  dec.sel = swap ? SEL_CTRL : SEL_MASK;
                10'd7:  dec.sel = swap ? SEL_MASK : SEL_CTRL;
                10'd8:  dec.sel = SEL_RAW;
                10'd9:  dec.sel = SEL_MSTAT;
                10'd10: dec.sel = SEL_CLR;
                10'd11: dec.sel = SEL_UCUR;
                10'd12: dec.sel = SEL_LCUR;
                default: dec.sel = SEL_NONE;
            endcase
        end
    end
endmodule

// File: rtl/lcd_regif_irq.sv
module lcd_regif_irq
    import lcd_regif_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [NIRQ-1:0] evt,
    input  logic            mask_we,
    input  logic            clr_we,
    input  logic [NIRQ-1:0] wdata,
    output logic [NIRQ-1:0] raw,
    output logic [NIRQ-1:0] mask,
    output logic [NIRQ-1:0] masked,
    output logic            irq
);
    logic [NIRQ-1:0] clr_bits;
    assign clr_bits = clr_we ? wdata : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            raw  <= '0;
            mask <= '0;
        end else begin
            raw <= (raw & ~clr_bits) | evt;
            if (mask_we) mask <= wdata;
        end
    end

    assign masked = raw & mask;
    assign irq    = |masked;

    p_set_wins_r7: assert property (@(posedge clk) disable iff (rst)
        (evt != '0) |=> ((raw & $past(evt)) == $past(evt)));
    p_clear_r7: assert property (@(posedge clk) disable iff (rst)
        (clr_we && evt == '0) |=> ((raw & $past(wdata)) == '0));
endmodule

// File: rtl/lcd_regif_geom.sv
module lcd_regif_geom
    import lcd_regif_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] tim0,
    input  logic [DATA_W-1:0] tim1,
    output logic [GEOM_W-1:0] cols,
    output logic [GEOM_W-1:0] rows
);
    localparam int PPL_W = 6;
    localparam int LPP_W = 10;
    logic [PPL_W:0] ppl_p1;

    assign ppl_p1 = {1'b0, tim0[2 +: PPL_W]} + 1'b1;
    assign cols   = GEOM_W'({ppl_p1, 4'b0000});
    assign rows   = GEOM_W'({1'b0, tim1[LPP_W-1:0]}) + 1'b1;

    p_cols_step_r3: assert property (@(posedge clk) disable iff (rst)
        cols[3:0] == 4'd0 && cols != '0);
    p_rows_nonzero_r4: assert property (@(posedge clk) disable iff (rst)
        rows != '0);
endmodule

// File: rtl/lcd_regif.sv
module lcd_regif
    import lcd_regif_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        variant,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    input  logic [NIRQ-1:0]   irq_evt,
    output logic              irq,
    output logic              redraw,
    output logic [GEOM_W-1:0] active_cols,
    output logic [GEOM_W-1:0] active_rows,
    output logic              pal_sel,
    output logic              pal_write,
    output logic [PAL_AW-1:0] pal_addr,
    output logic [DATA_W-1:0] pal_wdata,
    input  logic [DATA_W-1:0] pal_rdata
);
    decode_t                dec;
    logic                   wr_fire, rd_en;
    logic [DATA_W-1:0]      tim [NTIM];
    logic [DATA_W-1:0]      ubase, lbase;
    logic [CTRL_W-1:0]      ctrl;
    logic [NIRQ-1:0]        raw, mask, masked;
    variant_e               var_q;

    assign var_q   = variant_e'(variant);
    assign wr_fire = psel && penable && pwrite;
    assign rd_en   = psel && !pwrite;

    lcd_regif_decode u_dec (.paddr(paddr), .variant(var_q), .dec(dec));

    for (genvar i = 0; i < NTIM; i++) begin : g_tim
        always_ff @(posedge clk) begin
            if (rst) tim[i] <= '0;
            else if (wr_fire && dec.sel == SEL_TIM && dec.tim_idx == IDX_W'(i))
                tim[i] <= pwdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ubase  <= '0;
            lbase  <= '0;
            ctrl   <= '0;
            redraw <= 1'b0;
        end else begin
            redraw <= wr_fire;
            if (wr_fire) begin
                case (dec.sel)
                    SEL_UBASE: ubase <= pwdata;
                    SEL_LBASE: lbase <= pwdata;
                    SEL_CTRL:  ctrl  <= pwdata[CTRL_W-1:0];
                    default: ;
                endcase
            end
        end
    end

    lcd_regif_irq u_irq (
        .clk(clk), .rst(rst), .evt(irq_evt),
        .mask_we(wr_fire && dec.sel == SEL_MASK),
        .clr_we(wr_fire && dec.sel == SEL_CLR),
        .wdata(pwdata[NIRQ-1:0]),
        .raw(raw), .mask(mask), .masked(masked), .irq(irq)
    );

    lcd_regif_geom u_geom (
        .clk(clk), .rst(rst), .tim0(tim[0]), .tim1(tim[1]),
        .cols(active_cols), .rows(active_rows)
    );

    assign pal_sel   = psel && dec.sel == SEL_PAL;
    assign pal_write = pal_sel && wr_fire;
    assign pal_addr  = paddr[2 +: PAL_AW];
    assign pal_wdata = pwdata;

    always_comb begin
        prdata = '0;
        if (rd_en) begin
            case (dec.sel)
                SEL_TIM:   prdata = tim[dec.tim_idx];
                SEL_UBASE, SEL_UCUR: prdata = ubase;
                SEL_LBASE, SEL_LCUR: prdata = lbase;
                SEL_CTRL:  prdata = DATA_W'(ctrl);
                SEL_MASK:  prdata = DATA_W'(mask);
                SEL_RAW:   prdata = DATA_W'(raw);
                SEL_MSTAT: prdata = DATA_W'(masked);
                SEL_ID:    prdata = DATA_W'(id_byte(variant[1], dec.id_idx));
                SEL_PAL:   prdata = pal_rdata;
                default:   prdata = '0;
            endcase
        end
    end

    p_redraw_r11: assert property (@(posedge clk) disable iff (rst)
        (wr_fire && !rst) |=> redraw);
    p_redraw_once_r11: assert property (@(posedge clk) disable iff (rst)
        (!wr_fire) |=> !redraw);
endmodule

// File: tb/lcd_regif_bench.sv
module lcd_regif_bench;
    logic        clk = 0, rst = 1;
    logic [1:0]  variant = 0;
    logic        psel = 0, penable = 0, pwrite = 0;
    logic [11:0] paddr = 0;
    logic [31:0] pwdata = 0, prdata, pal_wdata, pal_rdata;
    logic [4:0]  irq_evt = 0;
    logic        irq, redraw, pal_sel, pal_write;
    logic [10:0] active_cols, active_rows;
    logic [6:0]  pal_addr;
    int checks = 0, errors = 0;
    logic [31:0] rd;

    always #5 clk = ~clk;
    assign pal_rdata = 32'h5A00_0000 | {25'b0, pal_addr};

    lcd_regif u_lcd_regif (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [4:0] ev = 0);
        @(negedge clk); psel = 1; pwrite = 1; paddr = a; pwdata = d;
        @(negedge clk); penable = 1; irq_evt = ev;
        @(negedge clk); psel = 0; penable = 0; pwrite = 0; irq_evt = 0;
        chk("R11 redraw after write", {31'b0, redraw}, 1);
        @(negedge clk);
        chk("R11 redraw single cycle", {31'b0, redraw}, 0);
    endtask

    task automatic rdw(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk); psel = 1; pwrite = 0; paddr = a;
        #1 d = prdata;
        @(negedge clk); psel = 0;
    endtask

    task automatic pulse(input logic [4:0] ev);
        @(negedge clk); irq_evt = ev;
        @(negedge clk); irq_evt = 0;
    endtask

    task automatic t_reset;
        for (int w = 0; w < 13; w++) begin
            rdw(12'(w * 4), rd); chk("R12 reset reg zero", rd, 0);
        end
        chk("R12 reset cols", 32'(active_cols), 16);
        chk("R12 reset rows", 32'(active_rows), 1);
        chk("R12 reset irq", {31'b0, irq}, 0);
        chk("R12 reset redraw", {31'b0, redraw}, 0);
    endtask

    task automatic t_regs;
        for (int w = 0; w < 6; w++) wr(12'(w * 4), 32'h1234_0000 + 32'(w * 32'h111));
        for (int w = 0; w < 6; w++) begin
            rdw(12'(w * 4), rd); chk("R1 readback", rd, 32'h1234_0000 + 32'(w * 32'h111));
        end
        rdw(12'h02C, rd); chk("R1 upper current", rd, 32'h1234_0444);
        rdw(12'h030, rd); chk("R1 lower current", rd, 32'h1234_0555);
    endtask

    task automatic t_geom;
        wr(12'h000, 32'h0000_00FC); chk("R3 cols max", 32'(active_cols), 1024);
        wr(12'h000, 32'hFFFF_FF03); chk("R3 cols masked", 32'(active_cols), 16);
        wr(12'h000, 32'h0000_0010); chk("R3 cols 80", 32'(active_cols), 80);
        wr(12'h004, 32'h0000_03FF); chk("R4 rows max", 32'(active_rows), 1024);
        wr(12'h004, 32'hFFFF_FC00); chk("R4 rows masked", 32'(active_rows), 1);
        wr(12'h004, 32'h0000_01DF); chk("R4 rows 480", 32'(active_rows), 480);
    endtask

    task automatic t_swap;
        variant = 0;
        wr(12'h018, 32'hFFFF_FFE5);
        wr(12'h01C, 32'h0001_ABCD);
        rdw(12'h018, rd); chk("R2 basic mask", rd, 32'h05);
        rdw(12'h01C, rd); chk("R2 basic ctrl", rd, 32'hABCD);
        for (int v = 1; v < 4; v++) begin
            variant = 2'(v);
            rdw(12'h018, rd); chk("R2 swapped ctrl", rd, 32'hABCD);
            rdw(12'h01C, rd); chk("R2 swapped mask", rd, 32'h05);
        end
        variant = 1;
        wr(12'h018, 32'h0000_1234);
        variant = 0;
        rdw(12'h01C, rd); chk("R2 swapped write ctrl", rd, 32'h1234);
        rdw(12'h018, rd); chk("R2 mask untouched", rd, 32'h05);
    endtask

    task automatic t_irq;
        variant = 0;
        pulse(5'h02);
        rdw(12'h020, rd); chk("R5 raw set", rd, 32'h02);
        rdw(12'h024, rd); chk("R6 masked none", rd, 0);
        chk("R6 irq low", {31'b0, irq}, 0);
        pulse(5'h01);
        rdw(12'h020, rd); chk("R5 raw two", rd, 32'h03);
        rdw(12'h024, rd); chk("R6 masked", rd, 32'h01);
        chk("R6 irq high", {31'b0, irq}, 1);
        wr(12'h028, 32'h01);
        rdw(12'h020, rd); chk("R7 clear", rd, 32'h02);
        chk("R7 irq dropped", {31'b0, irq}, 0);
        wr(12'h028, 32'h02, 5'h02);
        rdw(12'h020, rd); chk("R7 set wins", rd, 32'h02);
        wr(12'h028, 32'h1F);
        rdw(12'h020, rd); chk("R7 clear all", rd, 0);
        rdw(12'h028, rd); chk("R9 clear port reads zero", rd, 0);
    endtask

    task automatic t_id;
        logic [7:0] b0 [8] = '{8'h10, 8'h11, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
        for (int v = 0; v < 4; v++) begin
            variant = 2'(v);
            for (int i = 0; i < 8; i++) begin
                logic [7:0] e;
                e = b0[i];
                if (v >= 2 && i == 0) e = 8'h11;
                if (v >= 2 && i == 2) e = 8'h24;
                rdw(12'hFE0 + 12'(i * 4), rd); chk("R8 id byte", rd, 32'(e));
            end
        end
        variant = 0;
    endtask

    task automatic t_undef;
        wr(12'h034, 32'hFFFF_FFFF);
        wr(12'h100, 32'hFFFF_FFFF);
        wr(12'h400, 32'hFFFF_FFFF);
        wr(12'hFE0, 32'hFFFF_FFFF);
        rdw(12'h034, rd); chk("R9 undef read", rd, 0);
        rdw(12'h100, rd); chk("R9 undef read", rd, 0);
        rdw(12'h400, rd); chk("R9 undef read", rd, 0);
        rdw(12'h008, rd); chk("R9 tim2 kept", rd, 32'h1234_0222);
        rdw(12'h00C, rd); chk("R9 tim3 kept", rd, 32'h1234_0333);
        rdw(12'h010, rd); chk("R9 ubase kept", rd, 32'h1234_0444);
        rdw(12'h018, rd); chk("R9 mask kept", rd, 32'h05);
        rdw(12'h01C, rd); chk("R9 ctrl kept", rd, 32'h1234);
        chk("R9 cols kept", 32'(active_cols), 80);
        chk("R9 rows kept", 32'(active_rows), 480);
    endtask

    task automatic t_pal;
        @(negedge clk); psel = 1; pwrite = 0; paddr = 12'h2A4;
        #1;
        chk("R10 pal sel", {31'b0, pal_sel}, 1);
        chk("R10 pal no write", {31'b0, pal_write}, 0);
        chk("R10 pal index", 32'(pal_addr), 41);
        chk("R10 pal read", prdata, 32'h5A00_0029);
        @(negedge clk); psel = 1; pwrite = 1; paddr = 12'h3FC; pwdata = 32'hDEAD_BEEF;
        @(negedge clk); penable = 1;
        #1;
        chk("R10 pal write", {31'b0, pal_write}, 1);
        chk("R10 pal wdata", pal_wdata, 32'hDEAD_BEEF);
        chk("R10 pal index top", 32'(pal_addr), 127);
        @(negedge clk); psel = 0; penable = 0; pwrite = 0;
        chk("R11 redraw palette", {31'b0, redraw}, 1);
        @(negedge clk); paddr = 12'h1FC; psel = 1;
        #1 chk("R10 below range", {31'b0, pal_sel}, 0);
        @(negedge clk); psel = 0;
        rdw(12'h000, rd); chk("R10 tim0 kept", rd, 32'h10);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset;
        t_regs;
        t_geom;
        t_swap;
        t_irq;
        t_id;
        t_undef;
        t_pal;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #100000;
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule